// File: doc/BRIEF.md
# Key-Blob Status and Interrupt Controller

This block holds the control and status words that software uses to watch a key-unwrap engine serving four decryption contexts. A configuration word carries a block enable, a key-blob-initiated flag, a key-blob processing enable, an interrupt enable and a self-clearing forced-error test bit. A status word reports the following:
- whether processing has finished;
- mirrors of the two enables;
- a sticky aggregate error flag;
- one error bit per context.

The unwrap engine drives two inputs. One is a one-cycle done pulse. The other is a vector of one-cycle error pulses, one bit per context. The block raises a level interrupt while the aggregate error flag is set and interrupts are enabled. Software clears the error state by writing 1 to status bit 0. The forced-error bit lets software test the interrupt path without a real integrity failure. In that case no context is blamed.

The register port is a simple 32-bit write strobe with a combinational read. The configuration word is at byte offset 0x0 and the status word is at byte offset 0x4.

Top module: `kbs_status_top`

## Requirements
- R1: A cycle with any bit of `ctx_err_i` high sets status bit 0 and ORs the pulse into status bits 19:16 (bit 16+n for context n), visible after the next clock edge. Earlier context bits are kept.
- R2: Status bit 0 and bits 19:16 are sticky. A status write with data bit 0 = 1 clears all of them. A status write with bit 0 = 0 changes nothing. Status bits 19:16 are never nonzero while status bit 0 is 0.
- R3: A configuration write with data bit 1 = 1 sets status bit 0 and clears status bits 19:16. Configuration bit 1 always reads 0.
- R4: A context error pulse in the same cycle as a clearing status write wins. After the edge, status bit 0 is 1 and bits 19:16 equal that cycle's pulse vector alone.
- R5: `irq_o` is 1 exactly while configuration bit 0 (interrupt enable) and status bit 0 are both 1.
- R6: Status bit 31 becomes 1 after a `kb_done_i` pulse while configuration bit 5 (processing enable, 1 = enabled) is 1. It returns to 0 once bit 5 is written 0. A done pulse while bit 5 is 0 is ignored.
- R7: Status bit 30 reads configuration bit 5, and status bit 29 reads configuration bit 31.
- R8: Configuration bits 31 (block enable), 30 (key-blob initiated), 5 and 0 read back as written. Every other configuration bit reads 0. Offsets other than 0x0 and 0x4 read 0 and writes to them are ignored.
- R9: After reset both words read zero and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| ctx_err_i | input | 4 | Per-context integrity error pulses |
| kb_done_i | input | 1 | Key-blob processing finished pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps every pair of 4-bit error patterns, one after the other from a cleared state. A design that overwrote the context vector instead of accumulating it, or that set the flag on an all-zero pulse, mismatches the arithmetic expectation.

The bench also covers the following corner cases:
- A clear that collides with a fresh error. A design that let the clear win would lose a real error.
- A forced error raised on top of real ones. A design that kept the stale context bits would still blame the contexts.
- A done pulse with processing disabled, and the disable after done. A design that latched the pulse regardless, or lagged the disable, shows a wrong bit 31.
- The interrupt, checked across all four enable/flag combinations.

// File: rtl/kbs_pkg.sv
package kbs_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_CTX = 4;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CFG = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STA = 4'h4;

  // configuration word fields
  localparam int CFG_BLK_EN  = 31;
  localparam int CFG_KB_INIT = 30;
  localparam int CFG_KB_PROC = 5;
  localparam int CFG_FORCE   = 1;
  localparam int CFG_IRQ_EN  = 0;

  // status word fields
  localparam int STA_DONE    = 31;
  localparam int STA_KB_EN   = 30;
  localparam int STA_BLK_EN  = 29;
  localparam int STA_VEC_LSB = 16;
  localparam int STA_ERR     = 0;

  typedef struct packed {
    logic blk_en;
    logic kb_init;
    logic kb_proc;
    logic irq_en;
  } cfg_t;
endpackage

// File: rtl/kbs_cfg_regs.sv
module kbs_cfg_regs
  import kbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output cfg_t              cfg_nxt_o,
  output logic              force_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) begin
      cfg_d.blk_en  = wdata_i[CFG_BLK_EN];
      cfg_d.kb_init = wdata_i[CFG_KB_INIT];
      cfg_d.kb_proc = wdata_i[CFG_KB_PROC];
      cfg_d.irq_en  = wdata_i[CFG_IRQ_EN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  // forced error is a write-time strobe only; nothing is stored
  assign force_o   = wr_i & wdata_i[CFG_FORCE];
  assign cfg_o     = cfg_q;
  assign cfg_nxt_o = cfg_d;
endmodule

// File: rtl/kbs_err_track.sv
module kbs_err_track #(
  parameter int NUM_CTX = kbs_pkg::NUM_CTX
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTX-1:0] ctx_err_i,
  input  logic               force_i,
  input  logic               clr_i,
  output logic               err_o,
  output logic [NUM_CTX-1:0] vec_o
);
  logic               err_q;
  logic [NUM_CTX-1:0] vec_q;

  // new errors take priority over a clear landing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (err_q & ~clr_i) | (|ctx_err_i) | force_i;
  end

  for (genvar n = 0; n < NUM_CTX; n++) begin : g_ctx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_q[n] <= 1'b0;
      else         vec_q[n] <= ctx_err_i[n] | (vec_q[n] & ~clr_i & ~force_i);
    end
  end

  assign err_o = err_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/kbs_done_track.sv
module kbs_done_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic proc_en_nxt_i,
  input  logic done_i,
  output logic done_o
);
  logic done_q;

  // follows the enable's next value so a disable clears done on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= proc_en_nxt_i & (done_q | done_i);
  end

  assign done_o = done_q;
endmodule

// File: rtl/kbs_status_top.sv
module kbs_status_top
  import kbs_pkg::*;
#(
  parameter int NUM_CTX = kbs_pkg::NUM_CTX
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_CTX-1:0] ctx_err_i,
  input  logic               kb_done_i,
  output logic               irq_o
);
  localparam int VEC_MSB = STA_VEC_LSB + NUM_CTX - 1;

  cfg_t               cfg_q, cfg_nxt;
  logic               force_err;
  logic               err_flag;
  logic [NUM_CTX-1:0] err_vec;
  logic               kb_done_flag;
  logic               cfg_wr, sta_clr;

  assign cfg_wr  = we_i & (addr_i == OFS_CFG);
  assign sta_clr = we_i & (addr_i == OFS_STA) & wdata_i[STA_ERR];

  kbs_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr),
    .wdata_i   (wdata_i),
    .cfg_o     (cfg_q),
    .cfg_nxt_o (cfg_nxt),
    .force_o   (force_err)
  );

  kbs_err_track #(.NUM_CTX(NUM_CTX)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctx_err_i (ctx_err_i),
    .force_i   (force_err),
    .clr_i     (sta_clr),
    .err_o     (err_flag),
    .vec_o     (err_vec)
  );

  kbs_done_track u_done (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .proc_en_nxt_i (cfg_nxt.kb_proc),
    .done_i        (kb_done_i),
    .done_o        (kb_done_flag)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CFG: begin
        rdata_o[CFG_BLK_EN]  = cfg_q.blk_en;
        rdata_o[CFG_KB_INIT] = cfg_q.kb_init;
        rdata_o[CFG_KB_PROC] = cfg_q.kb_proc;
        rdata_o[CFG_IRQ_EN]  = cfg_q.irq_en;
      end
      OFS_STA: begin
        rdata_o[STA_DONE]                = kb_done_flag;
        rdata_o[STA_KB_EN]               = cfg_q.kb_proc;
        rdata_o[STA_BLK_EN]              = cfg_q.blk_en;
        rdata_o[VEC_MSB:STA_VEC_LSB]     = err_vec;
        rdata_o[STA_ERR]                 = err_flag;
      end
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = cfg_q.irq_en & err_flag;
endmodule

// File: rtl/kbs_status_chk.sv
module kbs_status_chk
  import kbs_pkg::*;
#(
  parameter int NUM_CTX = kbs_pkg::NUM_CTX
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_CTX-1:0] ctx_err_i,
  input logic               irq_o,
  input logic               err_q,
  input logic [NUM_CTX-1:0] vec_q,
  input logic               done_q,
  input logic               kb_proc
);
  logic clr_wr, force_wr;
  assign clr_wr   = we_i && addr_i == OFS_STA && wdata_i[STA_ERR];
  assign force_wr = we_i && addr_i == OFS_CFG && wdata_i[CFG_FORCE];

  a_r1_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ctx_err_i) |=> err_q);

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_wr) |=> err_q);

  a_r2_vec_follows_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_q |-> (vec_q == '0));

  a_r3_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_wr && !(|ctx_err_i)) |=> (err_q && vec_q == '0));

  a_r4_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && (|ctx_err_i)) |=> (err_q && vec_q == $past(ctx_err_i)));

  a_r5_irq_needs_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> err_q);

  a_r6_done_needs_proc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> kb_proc);
endmodule

bind kbs_status_top kbs_status_chk #(.NUM_CTX(NUM_CTX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .ctx_err_i (ctx_err_i),
  .irq_o     (irq_o),
  .err_q     (err_flag),
  .vec_q     (err_vec),
  .done_q    (kb_done_flag),
  .kb_proc   (cfg_q.kb_proc)
);

// File: tb/sim_kbs_status_top.sv
`timescale 1ns/1ps
module sim_kbs_status_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  ctx_err = '0;
  logic        kb_done = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  kbs_status_top u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .ctx_err_i (ctx_err),
    .kb_done_i (kb_done),
    .irq_o     (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] e);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; ctx_err = e;
    @(negedge clk);
    we = 1'b0; wdata = '0; ctx_err = '0;
  endtask

  task automatic pulse_ctx(input logic [3:0] e);
    @(negedge clk);
    ctx_err = e;
    @(negedge clk);
    ctx_err = '0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    kb_done = 1'b1;
    @(negedge clk);
    kb_done = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] sta_exp(input logic done, input logic kb, input logic blk,
                                          input logic [3:0] vec, input logic err);
    return (32'(done) << 31) | (32'(kb) << 30) | (32'(blk) << 29) | (32'(vec) << 16) | 32'(err);
  endfunction

  initial begin
    logic [31:0] d;
    logic [3:0]  acc;
    // reset state (R9)
    #1;
    rd(4'h0, d); check("R9 cfg reset", d, 32'h0);
    rd(4'h4, d); check("R9 sta reset", d, 32'h0);
    check("R9 irq reset", 32'(irq), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R2: all pattern pairs, accumulate from a cleared state
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        wr(4'h4, 32'h1, 4'h0);
        pulse_ctx(4'(p));
        rd(4'h4, d);
        check("R1 first pulse", d, sta_exp(0, 0, 0, 4'(p), p != 0));
        pulse_ctx(4'(q));
        acc = 4'(p) | 4'(q);
        rd(4'h4, d);
        check("R1 accumulate", d, sta_exp(0, 0, 0, acc, acc != 0));
      end
    end

    // R2: write 0 to status bit 0 and to upper bits has no effect
    wr(4'h4, 32'h1, 4'h0);
    pulse_ctx(4'h5);
    wr(4'h4, 32'hFFFF_FFFE, 4'h0);
    rd(4'h4, d); check("R2 no-clear write", d, sta_exp(0, 0, 0, 4'h5, 1));
    wr(4'h4, 32'h1, 4'h0);
    rd(4'h4, d); check("R2 clear", d, 32'h0);

    // R3: forced error over real errors clears the context vector
    pulse_ctx(4'hA);
    wr(4'h0, 32'h2, 4'h0);
    rd(4'h4, d); check("R3 force sets flag, clears vec", d, sta_exp(0, 0, 0, 4'h0, 1));
    rd(4'h0, d); check("R3 force bit reads 0", d, 32'h0);
    wr(4'h4, 32'h1, 4'h0);
    wr(4'h0, 32'h2, 4'h0);
    rd(4'h4, d); check("R3 force from clear", d, sta_exp(0, 0, 0, 4'h0, 1));

    // R4: clear colliding with new errors
    wr(4'h4, 32'h1, 4'h0);
    pulse_ctx(4'h3);
    for (int e = 1; e < 16; e++) begin
      wr(4'h4, 32'h1, 4'(e));
      rd(4'h4, d); check("R4 error beats clear", d, sta_exp(0, 0, 0, 4'(e), 1));
    end

    // R5: irq over enable x flag
    for (int ie = 0; ie < 2; ie++) begin
      for (int fl = 0; fl < 2; fl++) begin
        wr(4'h4, 32'h1, 4'h0);
        wr(4'h0, 32'(ie), 4'h0);
        if (fl != 0) pulse_ctx(4'h8);
        #1;
        check("R5 irq", 32'(irq), 32'((ie != 0) && (fl != 0)));
      end
    end
    wr(4'h4, 32'h1, 4'h0);
    #1; check("R5 irq drops on clear", 32'(irq), 32'h0);

    // R6/R7: done tracking and mirrors
    wr(4'h0, 32'h0, 4'h0);
    pulse_done();
    rd(4'h4, d); check("R6 done ignored when disabled", d, 32'h0);
    wr(4'h0, 32'h8000_0020, 4'h0);
    rd(4'h4, d); check("R7 mirrors", d, sta_exp(0, 1, 1, 4'h0, 0));
    pulse_done();
    rd(4'h4, d); check("R6 done set", d, sta_exp(1, 1, 1, 4'h0, 0));
    wr(4'h0, 32'h8000_0000, 4'h0);
    rd(4'h4, d); check("R6 done clears on disable", d, sta_exp(0, 0, 1, 4'h0, 0));
    wr(4'h0, 32'h0000_0020, 4'h0);
    rd(4'h4, d); check("R6 done stays clear on re-enable", d, sta_exp(0, 1, 0, 4'h0, 0));

    // R8: config field readback, unmapped offsets
    wr(4'h0, 32'hFFFF_FFFD, 4'h0);
    rd(4'h0, d); check("R8 cfg readback", d, 32'hC000_0021);
    wr(4'h8, 32'h0000_0000, 4'h0);
    rd(4'h0, d); check("R8 unmapped write ignored", d, 32'hC000_0021);
    rd(4'h8, d); check("R8 unmapped read", d, 32'h0);
    rd(4'hC, d); check("R8 unmapped read hi", d, 32'h0);
    wr(4'h0, 32'h0, 4'h0);
    rd(4'h0, d); check("R8 cfg cleared", d, 32'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule